// File: doc/BRIEF.md
# Junction Temperature Convolution Engine

This block estimates the junction temperature of a power device from a stream of power samples. Each sample stands for one fixed time step, and the step length is set by how often the surrounding logic offers a sample. The block keeps a short history of recent power samples. For every new sample it convolves that history with the step-to-step increments of a cumulative transient thermal impedance curve. It adds the ambient temperature to the result and produces the present junction temperature. It also keeps the highest value seen and a sticky flag that warns when that peak enters the safety margin below the device's temperature limit.

The impedance curve is written into a small internal table while the block is being configured. Entry `a` of the table holds the cumulative impedance at the end of step `a+1`, and the impedance at time zero is taken as zero. The block forms each increment by subtracting neighbouring entries, so a curve can be loaded directly from sampled impedance data. The arithmetic is unsigned fixed point: the block multiplies power by impedance and divides the sum by 2^FRAC to give degrees. A multiply-accumulate walks the history one term per clock, and a done strobe marks each new result.

Top module: `thermal_conv_engine`

## Requirements
- R1: While reset is held, and on the first cycle after it, `tj_out`, `tj_peak`, `over_flag` and `done` are all zero.
- R2: For each accepted sample, `tj_out` = `amb` + floor(S / 2^FRAC), where S is the sum over j = 0..DEPTH-1 of h[j]·(Z[j+1] − Z[j]). Here h[0] is the newest sample, h[j] is the sample accepted j steps earlier, and the sum takes zero for steps before the history filled and for samples older than DEPTH steps.
- R3: A cycle with `cfg_we` high stores `cfg_data` as Z[`cfg_addr`+1]. Z[0] is fixed at zero, and every table entry resets to zero.
- R4: `done` is high for exactly one cycle per accepted sample. It rises DEPTH+2 rising clock edges after the edge that accepts the sample (edge of acceptance counted as the first).
- R5: A `p_valid` pulse that arrives while a result is being computed is ignored: it neither enters the history nor alters the result.
- R6: On each `done`, `tj_peak` becomes the maximum of its previous value and the new `tj_out`. It never decreases except on clear.
- R7: `over_flag` sets on a `done` at which `tj_peak` > (`tj_max` − `margin`), with the threshold floored at zero when `margin` ≥ `tj_max`. An equal value does not set it. Once set, it stays set until clear or reset.
- R8: A one-cycle `clr` zeroes the history, `tj_peak` and `over_flag`, and abandons any result in progress so that no `done` follows for it.
- R9: `tj_out` saturates at 2^TW − 1 when `amb` plus the rise would exceed it.
- R10: When the sum S is negative (a non-monotonic table), the rise is taken as zero and `tj_out` equals `amb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Clears history, peak and flag; abandons a result in progress |
| cfg_we | input | 1 | Impedance table write enable |
| cfg_addr | input | AW | Table entry index (entry a holds Z[a+1]) |
| cfg_data | input | ZW | Cumulative impedance value, unsigned fixed point |
| p_valid | input | 1 | Offers one power sample for the current time step |
| p_data | input | PW | Power sample, unsigned fixed point |
| amb | input | TW | Ambient temperature |
| tj_max | input | TW | Maximum allowed junction temperature |
| margin | input | TW | Required margin below `tj_max` |
| tj_out | output | TW | Junction temperature for the latest step |
| tj_peak | output | TW | Highest junction temperature since reset or clear |
| over_flag | output | 1 | Sticky margin-violation flag |
| done | output | 1 | One-cycle strobe when a new result is ready |

## Verification
The engine is driven with several input patterns:
- An isolated impulse followed by zeros. This reproduces each table increment in turn and then falls back to ambient once the impulse leaves the history, so any error in indexing or in the history depth shows up.
- A constant step. This tests that the increments accumulate into the cumulative curve.
- A long arithmetic sequence of varied samples. This catches errors in the weighting and in the order of the history.
- Boundary cases:
  - a peak exactly equal to the threshold;
  - a threshold floored at zero;
  - a saturating ambient;
  - a decreasing table that drives the sum negative;
  - a sample offered mid-computation;
  - a clear issued mid-computation.

// File: rtl/zt_pkg.sv
// Package: shared types for the junction temperature convolution engine.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package zt_pkg;

    // Sequencer phases: waiting for a sample, accumulating terms, publishing.
    typedef enum logic [1:0] {
        ZT_IDLE = 2'd0,
        ZT_MAC  = 2'd1,
        ZT_FIN  = 2'd2
    } zt_state_e;

endpackage

// File: rtl/zt_hist_shift.sv
// Power history shift buffer.
// Holds the last DEPTH accepted power samples, stage 0 being the newest.
// A shift enters din at stage 0 and drops the oldest sample.
// Assumes rd_idx stays below DEPTH.
module zt_hist_shift #(
    parameter int PW    = 12,
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          shift_en,
    input  logic [PW-1:0] din,
    input  logic [AW-1:0] rd_idx,
    output logic [PW-1:0] rd_data
);

    logic [PW-1:0] stage [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            // Newest slot: loads the incoming sample on a shift.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    stage[g] <= '0;
                end else if (shift_en) begin
                    stage[g] <= din;
                end
            end
        end else begin : g_tail
            // Older slot: takes the value of its younger neighbour on a shift.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    stage[g] <= '0;
                end else if (shift_en) begin
                    stage[g] <= stage[g-1];
                end
            end
        end
    end

    // Read port used by the multiply-accumulate sequencer.
    assign rd_data = stage[rd_idx];

endmodule

// File: rtl/zt_coef_table.sv
// Cumulative thermal impedance table.
// Entry a stores the cumulative impedance at the end of step a+1.
// Written one entry per cycle during configuration and read asynchronously.
// Assumes writes do not overlap a computation whose result is expected to use the old curve.
module zt_coef_table #(
    parameter int ZW    = 12,
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [ZW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [ZW-1:0] rdata
);

    logic [ZW-1:0] entry [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        // One table register: reset to zero, loaded when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry[g] <= '0;
            end else if (we && (waddr == AW'(g))) begin
                entry[g] <= wdata;
            end
        end
    end

    // Combinational read of the entry for the current term.
    assign rdata = entry[raddr];

endmodule

// File: rtl/zt_mac_seq.sv
// Convolution sequencer and accumulator.
// Accepts a sample when idle and walks the history one term per cycle.
// Each term is the history value times the increment Z[j+1]-Z[j], with Z[0]=0.
// The increment is formed from the previous table read, so the table holds cumulative values.
// A sample offered while busy is ignored. Clear abandons the current sum.
module zt_mac_seq
    import zt_pkg::*;
#(
    parameter int PW    = 12,
    parameter int ZW    = 12,
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int ACCW  = PW + ZW + 2 + AW
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   p_valid,
    input  logic [PW-1:0]          hist_data,
    input  logic [ZW-1:0]          coef_data,
    output logic                   shift_en,
    output logic [AW-1:0]          rd_idx,
    output logic                   fin_en,
    output logic signed [ACCW-1:0] acc
);

    localparam int            PRODW = PW + ZW + 2;
    localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);

    zt_state_e               state;
    logic [AW-1:0]           idx;
    logic [ZW-1:0]           zprev;
    logic signed [ZW:0]      dz;
    logic signed [PRODW-1:0] term;

    // Increment of the cumulative curve and its weighted term for this index.
    always_comb begin
        dz   = $signed({1'b0, coef_data}) - $signed({1'b0, zprev});
        term = $signed({1'b0, hist_data}) * dz;
    end

    // A new sample enters only when the sequencer is idle.
    assign shift_en = (state == ZT_IDLE) && p_valid && !clr;
    assign rd_idx   = idx;
    assign fin_en   = (state == ZT_FIN);

    // Phase control, term index and running sum.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state <= ZT_IDLE;
            idx   <= '0;
            zprev <= '0;
            acc   <= '0;
        end else begin
            unique case (state)
                ZT_IDLE: begin
                    if (p_valid) begin
                        state <= ZT_MAC;
                        idx   <= '0;
                        zprev <= '0;
                        acc   <= '0;
                    end
                end
                ZT_MAC: begin
                    acc   <= acc + ACCW'(term);
                    zprev <= coef_data;
                    if (idx == LAST) begin
                        state <= ZT_FIN;
                    end else begin
                        idx <= idx + AW'(1);
                    end
                end
                ZT_FIN: begin
                    state <= ZT_IDLE;
                end
                default: begin
                    state <= ZT_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/zt_peak_track.sv
// Result stage.
// Scales the sum, clamps a negative sum to zero and adds ambient, saturating at the maximum code.
// Keeps the running peak and a sticky flag for a peak above (tj_max - margin).
// The threshold floors at zero. Ambient, limit and margin are sampled in the publishing cycle.
module zt_peak_track #(
    parameter int TW   = 16,
    parameter int ACCW = 30,
    parameter int FRAC = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   fin_en,
    input  logic signed [ACCW-1:0] acc,
    input  logic [TW-1:0]          amb,
    input  logic [TW-1:0]          tj_max,
    input  logic [TW-1:0]          margin,
    output logic [TW-1:0]          tj_out,
    output logic [TW-1:0]          tj_peak,
    output logic                   over_flag,
    output logic                   done
);

    localparam int            SW   = ((ACCW > TW) ? ACCW : TW) + 1;
    localparam logic [SW-1:0] TMAX = SW'((64'd1 << TW) - 64'd1);

    logic signed [ACCW-1:0] shifted;
    logic [ACCW-1:0]        rise;
    logic [SW-1:0]          sum;
    logic [TW-1:0]          tj_new;
    logic [TW-1:0]          peak_new;
    logic [TW-1:0]          thr;

    // Temperature for this step, the new peak and the violation threshold.
    always_comb begin
        shifted  = acc >>> FRAC;
        rise     = acc[ACCW-1] ? '0 : $unsigned(shifted);
        sum      = SW'(rise) + SW'(amb);
        tj_new   = (sum > TMAX) ? TMAX[TW-1:0] : sum[TW-1:0];
        peak_new = (tj_new > tj_peak) ? tj_new : tj_peak;
        thr      = (tj_max > margin) ? (tj_max - margin) : '0;
    end

    // Publish the result, update peak and flag, pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tj_out    <= '0;
            tj_peak   <= '0;
            over_flag <= 1'b0;
            done      <= 1'b0;
        end else if (clr) begin
            tj_peak   <= '0;
            over_flag <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= fin_en;
            if (fin_en) begin
                tj_out  <= tj_new;
                tj_peak <= peak_new;
                if (peak_new > thr) begin
                    over_flag <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/thermal_conv_engine.sv
// Junction temperature convolution engine (top).
// Convolves the power history with increments of a cumulative thermal impedance curve.
// Then adds ambient, tracks the peak and flags entry into the margin.
// One result per accepted sample, DEPTH+2 cycles after acceptance.
// Assumes samples arrive no faster than one per DEPTH+2 cycles.
module thermal_conv_engine #(
    parameter int PW    = 12,
    parameter int ZW    = 12,
    parameter int TW    = 16,
    parameter int DEPTH = 16,
    parameter int FRAC  = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [ZW-1:0] cfg_data,
    input  logic          p_valid,
    input  logic [PW-1:0] p_data,
    input  logic [TW-1:0] amb,
    input  logic [TW-1:0] tj_max,
    input  logic [TW-1:0] margin,
    output logic [TW-1:0] tj_out,
    output logic [TW-1:0] tj_peak,
    output logic          over_flag,
    output logic          done
);

    localparam int ACCW = PW + ZW + 2 + AW;

    logic                   shift_en;
    logic                   fin_en;
    logic [AW-1:0]          rd_idx;
    logic [PW-1:0]          hist_data;
    logic [ZW-1:0]          coef_data;
    logic signed [ACCW-1:0] acc;

    zt_hist_shift #(.PW(PW), .DEPTH(DEPTH), .AW(AW)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .shift_en (shift_en),
        .din      (p_data),
        .rd_idx   (rd_idx),
        .rd_data  (hist_data)
    );

    zt_coef_table #(.ZW(ZW), .DEPTH(DEPTH), .AW(AW)) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .waddr (cfg_addr),
        .wdata (cfg_data),
        .raddr (rd_idx),
        .rdata (coef_data)
    );

    zt_mac_seq #(.PW(PW), .ZW(ZW), .DEPTH(DEPTH), .AW(AW), .ACCW(ACCW)) u_mac (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .p_valid   (p_valid),
        .hist_data (hist_data),
        .coef_data (coef_data),
        .shift_en  (shift_en),
        .rd_idx    (rd_idx),
        .fin_en    (fin_en),
        .acc       (acc)
    );

    zt_peak_track #(.TW(TW), .ACCW(ACCW), .FRAC(FRAC)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .fin_en    (fin_en),
        .acc       (acc),
        .amb       (amb),
        .tj_max    (tj_max),
        .margin    (margin),
        .tj_out    (tj_out),
        .tj_peak   (tj_peak),
        .over_flag (over_flag),
        .done      (done)
    );

endmodule

// File: rtl/thermal_conv_engine_chk.sv
// Property checker for the convolution engine, attached by bind.
// Watches only the top-level ports.
module thermal_conv_engine_chk #(
    parameter int TW = 16,
    parameter int AW = 4,
    parameter int PW = 12,
    parameter int ZW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clr,
    input logic          cfg_we,
    input logic [AW-1:0] cfg_addr,
    input logic [ZW-1:0] cfg_data,
    input logic          p_valid,
    input logic [PW-1:0] p_data,
    input logic [TW-1:0] amb,
    input logic [TW-1:0] tj_max,
    input logic [TW-1:0] margin,
    input logic [TW-1:0] tj_out,
    input logic [TW-1:0] tj_peak,
    input logic          over_flag,
    input logic          done
);

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    peak_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (tj_peak >= $past(tj_peak)));

    // R6
    peak_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (tj_peak >= tj_out));

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (over_flag && !clr) |=> over_flag);

    // R7
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(over_flag) |->
            (({1'b0, tj_peak} + {1'b0, $past(margin)}) > {1'b0, $past(tj_max)}));

    // R8
    clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((tj_peak == '0) && !over_flag && !done));

endmodule

bind thermal_conv_engine thermal_conv_engine_chk #(
    .TW (TW),
    .AW (AW),
    .PW (PW),
    .ZW (ZW)
) u_chk (.*);

// File: tb/thermal_conv_engine_bench.sv
`timescale 1ns/1ps
module thermal_conv_engine_bench;

    localparam int PW    = 8;
    localparam int ZW    = 8;
    localparam int TW    = 12;
    localparam int DEPTH = 8;
    localparam int FRAC  = 4;
    localparam int AW    = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [ZW-1:0] cfg_data = '0;
    logic          p_valid = 1'b0;
    logic [PW-1:0] p_data = '0;
    logic [TW-1:0] amb = '0;
    logic [TW-1:0] tj_max = '0;
    logic [TW-1:0] margin = '0;
    logic [TW-1:0] tj_out;
    logic [TW-1:0] tj_peak;
    logic          over_flag;
    logic          done;

    int     checks = 0;
    int     fails = 0;
    bit     finished = 1'b0;
    longint mh [DEPTH];
    longint mz [DEPTH+1];
    longint mpeak = 0;
    bit     mflag = 1'b0;

    always #10 clk = ~clk;

    thermal_conv_engine #(
        .PW(PW), .ZW(ZW), .TW(TW), .DEPTH(DEPTH), .FRAC(FRAC)
    ) u_thermal_conv_engine (
        .clk(clk), .rst_n(rst_n), .clr(clr), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .p_valid(p_valid),
        .p_data(p_data), .amb(amb), .tj_max(tj_max), .margin(margin),
        .tj_out(tj_out), .tj_peak(tj_peak), .over_flag(over_flag), .done(done)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected temperature from the convolution requirement (R2, R9, R10)
    function automatic longint exp_tj();
        longint s = 0;
        for (int j = 0; j < DEPTH; j++) s += mh[j] * (mz[j+1] - mz[j]);
        if (s < 0) s = 0;
        s = s / (64'sd1 << FRAC);
        s += longint'(amb);
        if (s > 4095) s = 4095;
        return s;
    endfunction

    function automatic longint thr_now();
        return (tj_max > margin) ? longint'(tj_max) - longint'(margin) : 0;
    endfunction

    // R3: table write of Z[a+1]
    task automatic load(input int a, input int z);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = AW'(a); cfg_data = ZW'(z);
        @(negedge clk);
        cfg_we = 1'b0;
        mz[a+1] = z;
    endtask

    task automatic send(input int p, input bit inject, input string req);
        int cnt = 0;
        bit got = 1'b0;
        longint e;
        @(negedge clk);
        p_valid = 1'b1; p_data = PW'(p);
        while (!got && cnt < 100) begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            if (inject && cnt == 3) begin
                p_valid = 1'b1; p_data = 8'd99;
            end else begin
                p_valid = 1'b0;
            end
            if (done) got = 1'b1;
        end
        for (int j = DEPTH - 1; j > 0; j--) mh[j] = mh[j-1];
        mh[0] = p;
        e = exp_tj();
        if (e > mpeak) mpeak = e;
        if (mpeak > thr_now()) mflag = 1'b1;
        chk("R4 latency", cnt, DEPTH + 2);
        chk(req, tj_out, e);
        chk("R6 peak", tj_peak, mpeak);
        chk("R7 flag", over_flag, mflag);
    endtask

    task automatic clear_model();
        for (int j = 0; j < DEPTH; j++) mh[j] = 0;
        mpeak = 0;
        mflag = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        clear_model();
        chk("R8 peak cleared", tj_peak, 0);
        chk("R8 flag cleared", over_flag, 0);
    endtask

    initial begin
        for (int j = 0; j < DEPTH; j++) mh[j] = 0;
        for (int j = 0; j <= DEPTH; j++) mz[j] = 0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 tj_out", tj_out, 0);
        chk("R1 tj_peak", tj_peak, 0);
        chk("R1 over_flag", over_flag, 0);
        chk("R1 done", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done after release", done, 0);

        amb = 12'd250; tj_max = 12'd1500; margin = 12'd20;
        // R3: load cumulative curve
        load(0, 20);  load(1, 45);  load(2, 70);  load(3, 90);
        load(4, 105); load(5, 115); load(6, 120); load(7, 122);

        // R2: impulse walks each increment then falls off the history
        send(160, 1'b0, "R2 impulse");
        for (int i = 0; i < 9; i++) send(0, 1'b0, "R2 impulse tail");
        // R2: step accumulates the curve
        for (int i = 0; i < 10; i++) send(50, 1'b0, "R2 step");
        // R2: varied sequence
        for (int i = 0; i < 40; i++) send((i * 73 + 17) % 256, 1'b0, "R2 sweep");
        amb = 12'd30;
        for (int i = 0; i < 5; i++) send((i * 41 + 200) % 256, 1'b0, "R2 ambient");
        // R5: sample offered while busy is ignored
        send(30, 1'b1, "R5 busy ignore");
        send(0, 1'b1, "R5 busy ignore");
        send(0, 1'b0, "R5 after ignore");

        // R7: equal-to-threshold does not set, exceeding does, then sticky
        pulse_clear();
        amb = 12'd250; tj_max = 12'd300; margin = 12'd25;
        send(20, 1'b0, "R7 equal");
        chk("R7 equal no flag", over_flag, 0);
        send(0, 1'b0, "R7 exceed");
        chk("R7 exceed flag", over_flag, 1);
        for (int i = 0; i < 9; i++) send(0, 1'b0, "R7 sticky");
        chk("R7 sticky flag", over_flag, 1);

        // R7: threshold floored at zero
        pulse_clear();
        amb = 12'd0; tj_max = 12'd100; margin = 12'd400;
        send(0, 1'b0, "R7 floor zero");
        chk("R7 floor no flag", over_flag, 0);
        send(1, 1'b0, "R7 floor one");
        chk("R7 floor flag", over_flag, 1);

        // R8: clear mid-computation abandons the result
        tj_max = 12'd4095; margin = 12'd0; amb = 12'd250;
        send(100, 1'b0, "R8 preload");
        @(negedge clk); p_valid = 1'b1; p_data = 8'd200;
        @(negedge clk); p_valid = 1'b0;
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        clear_model();
        begin
            bit seen = 1'b0;
            for (int i = 0; i < DEPTH + 4; i++) begin
                @(negedge clk);
                if (done) seen = 1'b1;
            end
            chk("R8 no done after clear", seen, 0);
        end
        chk("R8 peak", tj_peak, 0);
        chk("R8 flag", over_flag, 0);
        send(0, 1'b0, "R8 empty history");

        // R9: saturation
        amb = 12'd4000;
        send(255, 1'b0, "R9 saturate");
        chk("R9 max code", tj_out, 4095);

        // R10: negative sum clamps to ambient
        pulse_clear();
        amb = 12'd100;
        load(0, 200); load(1, 10);
        send(255, 1'b0, "R10 rise");
        send(0, 1'b0, "R10 negative");
        chk("R10 ambient", tj_out, 100);
        send(0, 1'b0, "R10 recover");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #3000000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule